// File: doc/BRIEF.md
# Transmit Rate Pacing Counter

This block paces the bytes of outgoing cells. A programmable down counter steps once per byte-time tick. When it reaches zero, it reloads from a stored reload value. A registered permit output tells the byte serialiser when it may send. The block has two permit modes:

- **Strict mode:** sending is allowed only while the count sits at zero.
- **Early mode:** sending is allowed while the count is below a fixed threshold of 16.

A single load strobe captures the whole parameter set at once. The set is the reload value, the early-mode bit, and two control bits. The control bits switch off link handshaking and header checksum generation downstream. The same strobe also restarts the counter from the new reload value. Between loads, all settings hold.

The block is meant to sit beside the transmit serialiser. Software writes the parameters through a command register, and the byte-rate strobe comes from the line clocking logic.

Top module: `tx_pace_ctrl`

## Requirements
- R1: In reset and on the first cycle after it, the stored reload value is 0, the count is 0, early mode is off, `hs_off_o` and `chk_off_o` are 0, and `permit_o` is 1.
- R2: When `pace_ld` is 1 at a clock edge, the following are captured at that edge: `pace_reload`, `pace_early`, `hs_off_in` and `chk_off_in`. The count becomes the new reload value at the same edge. A load takes priority over a tick that arrives in the same cycle.
- R3: On an edge with `byte_tick` 1, `pace_ld` 0 and a nonzero count, the count drops by exactly one.
- R4: On an edge with `byte_tick` 1, `pace_ld` 0 and a count of zero, the count reloads with the stored reload value.
- R5: On an edge with neither `byte_tick` nor `pace_ld`, the count holds its value.
- R6: With early mode off, `permit_o` is 1 exactly when the count held in the count register is zero. `permit_o` is a registered output that changes only at the clock edge where the count changes.
- R7: With early mode on, `permit_o` is 1 exactly when the held count is less than 16.
- R8: `hs_off_o` and `chk_off_o` show the values captured by the last load. They do not change without a load.
- R9: With a stored reload value of 0, the count stays at zero and `permit_o` stays 1 on every cycle, in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pace_ld | input | 1 | Parameter load strobe |
| pace_reload | input | CNT_W | Reload value for the pacing counter |
| pace_early | input | 1 | Early-mode select (1 = permit below threshold) |
| hs_off_in | input | 1 | Handshake disable bit to capture |
| chk_off_in | input | 1 | Header checksum disable bit to capture |
| byte_tick | input | 1 | One-cycle strobe per byte transmit period |
| permit_o | output | 1 | Registered transmit permit |
| hs_off_o | output | 1 | Handshake disable control |
| chk_off_o | output | 1 | Header checksum disable control |

## Verification
The bound checker watches the counter register directly and checks on every cycle:

- each step rule: load, decrement, reload at zero, and hold;
- that the permit output matches the held count under the active mode;
- that the two disable controls move only on a load.

The reset values, and the full length of the pacing period as seen only through the permit pin, need the bench's scenarios. These include early-mode windows with reloads above the threshold, the zero-reload case, and a load that collides with a tick. A random stream of loads and ticks is checked against an independent counter model in the bench.

// File: rtl/tx_pace_pkg.sv
package tx_pace_pkg;

    localparam int DEF_CNT_W       = 8;
    localparam int DEF_EARLY_LIMIT = 16;

    // Mode bits captured with each parameter load
    typedef struct packed {
        logic early;
        logic hs_off;
        logic chk_off;
    } pace_mode_t;

    localparam pace_mode_t MODE_RESET = '{early: 1'b0, hs_off: 1'b0, chk_off: 1'b0};

    // Counter step selection
    typedef enum logic [1:0] {
        STEP_HOLD   = 2'd0,
        STEP_DEC    = 2'd1,
        STEP_RELOAD = 2'd2,
        STEP_LOAD   = 2'd3
    } pace_step_e;

    function automatic pace_step_e pick_step(input logic ld, input logic tick,
                                             input logic at_zero);
        if (ld)
            return STEP_LOAD;
        else if (!tick)
            return STEP_HOLD;
        else if (at_zero)
            return STEP_RELOAD;
        else
            return STEP_DEC;
    endfunction

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/pace_cfg_reg.sv
module pace_cfg_reg
    import tx_pace_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] reload_in,
    input  pace_mode_t       mode_in,
    output logic [CNT_W-1:0] reload_q,
    output pace_mode_t       mode_q,
    output logic             early_d
);

    logic [CNT_W-1:0] reload_d;
    pace_mode_t       mode_d;

    always_comb begin
        reload_d = reload_q;
        mode_d   = mode_q;
        if (load) begin
            reload_d = reload_in;
            mode_d   = mode_in;
        end
    end

    assign early_d = mode_d.early;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            mode_q   <= MODE_RESET;
        end else begin
            reload_q <= reload_d;
            mode_q   <= mode_d;
        end
    end

endmodule

// File: rtl/pace_down_counter.sv
module pace_down_counter
    import tx_pace_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    pace_step_e step;
    logic       at_zero;

    assign at_zero = (cnt_q == '0);
    assign step    = pick_step(load, tick, at_zero);

    always_comb begin
        unique case (step)
            STEP_LOAD:   cnt_d = load_val;
            STEP_RELOAD: cnt_d = reload_q;
            STEP_DEC:    cnt_d = cnt_q - ONE;
            default:     cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/pace_permit_gen.sv
module pace_permit_gen
    import tx_pace_pkg::*;
#(
    parameter int CNT_W       = DEF_CNT_W,
    parameter int EARLY_LIMIT = DEF_EARLY_LIMIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic             early_d,
    output logic             permit_q
);

    localparam int LIM_LOG = $clog2(EARLY_LIMIT);

    logic zero_d;
    logic below_d;

    assign zero_d = (cnt_d == '0);

    // Threshold compare: a power-of-two limit reduces to an upper-bit zero test
    generate
        if (is_pow2(EARLY_LIMIT)) begin : g_pow2
            if (CNT_W > LIM_LOG) begin : g_upper
                assign below_d = (cnt_d[CNT_W-1:LIM_LOG] == '0);
            end else begin : g_all
                assign below_d = 1'b1;
            end
        end else begin : g_cmp
            assign below_d = (int'(cnt_d) < EARLY_LIMIT);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            permit_q <= 1'b1;
        else
            permit_q <= early_d ? below_d : zero_d;
    end

endmodule

// File: rtl/tx_pace_ctrl.sv
module tx_pace_ctrl
    import tx_pace_pkg::*;
#(
    parameter int CNT_W       = DEF_CNT_W,
    parameter int EARLY_LIMIT = DEF_EARLY_LIMIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pace_ld,
    input  logic [CNT_W-1:0] pace_reload,
    input  logic             pace_early,
    input  logic             hs_off_in,
    input  logic             chk_off_in,
    input  logic             byte_tick,
    output logic             permit_o,
    output logic             hs_off_o,
    output logic             chk_off_o
);

    pace_mode_t       mode_in;
    pace_mode_t       mode_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             early_d;

    assign mode_in = '{early: pace_early, hs_off: hs_off_in, chk_off: chk_off_in};

    pace_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (pace_ld),
        .reload_in (pace_reload),
        .mode_in   (mode_in),
        .reload_q  (reload_q),
        .mode_q    (mode_q),
        .early_d   (early_d)
    );

    pace_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (pace_ld),
        .tick     (byte_tick),
        .load_val (pace_reload),
        .reload_q (reload_q),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d)
    );

    pace_permit_gen #(.CNT_W(CNT_W), .EARLY_LIMIT(EARLY_LIMIT)) u_permit (
        .clk      (clk),
        .rst      (rst),
        .cnt_d    (cnt_d),
        .early_d  (early_d),
        .permit_q (permit_o)
    );

    assign hs_off_o  = mode_q.hs_off;
    assign chk_off_o = mode_q.chk_off;

endmodule

// File: rtl/tx_pace_chk.sv
module tx_pace_chk #(
    parameter int CNT_W       = 8,
    parameter int EARLY_LIMIT = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             pace_ld,
    input logic [CNT_W-1:0] pace_reload,
    input logic             hs_off_in,
    input logic             chk_off_in,
    input logic             byte_tick,
    input logic             permit_o,
    input logic             hs_off_o,
    input logic             chk_off_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] reload_q,
    input logic             early_q
);

    AST_LOAD_SETS_COUNT: assert property (@(posedge clk) disable iff (rst)
        pace_ld |=> (cnt_q == $past(pace_reload))); // R2

    AST_TICK_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (!pace_ld && byte_tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

    AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (!pace_ld && byte_tick && cnt_q == '0) |=> (cnt_q == $past(reload_q))); // R4

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pace_ld && !byte_tick) |=> $stable(cnt_q)); // R5

    AST_PERMIT_STRICT: assert property (@(posedge clk) disable iff (rst)
        !early_q |-> (permit_o == (cnt_q == '0))); // R6

    AST_PERMIT_EARLY: assert property (@(posedge clk) disable iff (rst)
        early_q |-> (permit_o == (int'(cnt_q) < EARLY_LIMIT))); // R7

    AST_DISABLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !pace_ld |=> ($stable(hs_off_o) && $stable(chk_off_o))); // R8

    AST_DISABLE_LOAD: assert property (@(posedge clk) disable iff (rst)
        pace_ld |=> (hs_off_o == $past(hs_off_in) && chk_off_o == $past(chk_off_in))); // R8

    AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (reload_q == '0 && cnt_q == '0 && !pace_ld) |=> (cnt_q == '0)); // R9

endmodule

bind tx_pace_ctrl tx_pace_chk #(.CNT_W(CNT_W), .EARLY_LIMIT(EARLY_LIMIT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pace_ld     (pace_ld),
    .pace_reload (pace_reload),
    .hs_off_in   (hs_off_in),
    .chk_off_in  (chk_off_in),
    .byte_tick   (byte_tick),
    .permit_o    (permit_o),
    .hs_off_o    (hs_off_o),
    .chk_off_o   (chk_off_o),
    .cnt_q       (cnt_q),
    .reload_q    (reload_q),
    .early_q     (mode_q.early)
);

// File: tb/test_tx_pace_ctrl.sv
`timescale 1ns/1ps
module test_tx_pace_ctrl;

    localparam int W   = 8;
    localparam int LIM = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         pace_ld;
    logic [W-1:0] pace_reload;
    logic         pace_early;
    logic         hs_off_in;
    logic         chk_off_in;
    logic         byte_tick;
    logic         permit_o;
    logic         hs_off_o;
    logic         chk_off_o;

    int checks   = 0;
    int failures = 0;

    // Bench model state
    int m_cnt;
    int m_reload;
    bit m_early;
    bit m_hs;
    bit m_chk;

    always #2.5 clk = ~clk;

    tx_pace_ctrl #(.CNT_W(W), .EARLY_LIMIT(LIM)) i_tx_pace_ctrl (
        .clk         (clk),
        .rst         (rst),
        .pace_ld     (pace_ld),
        .pace_reload (pace_reload),
        .pace_early  (pace_early),
        .hs_off_in   (hs_off_in),
        .chk_off_in  (chk_off_in),
        .byte_tick   (byte_tick),
        .permit_o    (permit_o),
        .hs_off_o    (hs_off_o),
        .chk_off_o   (chk_off_o)
    );

    function automatic bit exp_permit(int cnt, bit early);
        if (early)
            return cnt < LIM;
        return cnt == 0;
    endfunction

    function automatic string permit_tag(int reload, bit early);
        if (reload == 0)
            return "R9";
        return early ? "R7" : "R6";
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs(string tag_p);
        bit ep;
        ep = exp_permit(m_cnt, m_early);
        check(permit_o == ep, tag_p, int'(permit_o), int'(ep));
        check(hs_off_o == m_hs && chk_off_o == m_chk, "R8",
              int'({hs_off_o, chk_off_o}), int'({m_hs, m_chk}));
    endtask

    // One clock with given inputs; model updated at the edge, outputs compared after it
    task automatic step(bit ld, int rl, bit early, bit hs, bit chk, bit tick, string tag_p);
        @(negedge clk);
        pace_ld     = ld;
        pace_reload = W'(rl);
        pace_early  = early;
        hs_off_in   = hs;
        chk_off_in  = chk;
        byte_tick   = tick;
        @(posedge clk);
        if (ld) begin
            m_reload = rl % (1 << W);
            m_early  = early;
            m_hs     = hs;
            m_chk    = chk;
            m_cnt    = m_reload;
        end else if (tick) begin
            if (m_cnt == 0)
                m_cnt = m_reload;
            else
                m_cnt = m_cnt - 1;
        end
        #1;
        check_outputs(tag_p);
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5A17_C0DE);
        rst = 1'b1; pace_ld = 0; pace_reload = '0; pace_early = 0;
        hs_off_in = 0; chk_off_in = 0; byte_tick = 0;
        m_cnt = 0; m_reload = 0; m_early = 0; m_hs = 0; m_chk = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        check(permit_o == 1'b1, "R1", int'(permit_o), 1);
        check(hs_off_o == 0 && chk_off_o == 0, "R1", int'({hs_off_o, chk_off_o}), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(permit_o == 1'b1, "R1", int'(permit_o), 1);

        // R9: zero reload after reset, ticking keeps permit high
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, "R9");

        // R2/R3/R4/R6: strict mode, reload 5
        step(1, 5, 0, 1, 0, 0, "R2");
        check(permit_o == 0, "R2", int'(permit_o), 0);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 1, "R3");
        check(permit_o == 1, "R6", int'(permit_o), 1);
        step(0, 0, 0, 0, 0, 1, "R4");
        check(permit_o == 0, "R4", int'(permit_o), 0);

        // R5: no tick holds the count
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 1, "R3");

        // R2: load colliding with tick wins
        step(1, 3, 0, 0, 1, 1, "R2");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, "R2");

        // R7: early mode, reload 20 spans the threshold
        step(1, 20, 1, 1, 1, 0, "R7");
        check(permit_o == 0, "R7", int'(permit_o), 0);
        for (int i = 0; i < 25; i++) step(0, 0, 0, 0, 0, 1, "R7");

        // R7: early mode reload below threshold: always permitted
        step(1, 10, 1, 0, 0, 0, "R7");
        for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 0, 1, "R7");

        // R9: zero reload in early mode
        step(1, 0, 1, 1, 0, 1, "R9");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, "R9");

        // Random stream
        for (int i = 0; i < 4000; i++) begin
            bit ld, tick, er, hs, ck;
            int rl;
            ld   = ($urandom % 16) == 0;
            tick = ($urandom % 4) != 0;
            er   = $urandom % 2;
            hs   = $urandom % 2;
            ck   = $urandom % 2;
            rl   = (($urandom % 3) == 0) ? int'($urandom % 256) : int'($urandom % 24);
            step(ld, rl, er, hs, ck, tick, ld ? "R2" : permit_tag(m_reload, m_early));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule